// File: doc/BRIEF.md
# Address Window Decoder

This block sits beside a memory-copy or fill engine and classifies every address the engine is about to issue. A small set of programmable windows describes the memory targets: one per DRAM chip-select plus one spare window. Each window has a 64 KB-aligned base, a size mask counted in 64 KB units, an enable bit, a two-bit permission field and an attribute byte. The attribute byte tells the fabric which target the access goes to. For DRAM chip-selects 0 to 3 the conventional attribute codes are 0x0E, 0x0D, 0x0B and 0x07.

A lookup is presented for one cycle with its address and a write flag. One cycle later the block returns exactly one of three outcomes: a hit, a decode miss or a protection violation. With a hit or a violation it also returns the index and attribute of the selected window. When several windows claim the address, the lowest index takes it. Software programs and reads back the windows through a word-addressed register port. That port also holds an address-override word, which resets to zero (meaning no override) and is only stored.

Register map (word offsets): 0 = control, 1 = override, 2+2i = base of window i, 3+2i = size of window i.

Top module: `awd_decoder`

## Requirements
- R1: After reset every register reads zero (the override word included), all windows are disabled, and any lookup reports a decode miss.
- R2: Control reads back only enable bits i and permission fields 16+2i..17+2i for existing windows, and zero elsewhere. Override reads back all 32 bits. Base reads back bits [31:8] with [7:0] zero. Size reads back bits [31:16] with [15:0] zero. Writes to offsets beyond the last window change nothing, and those offsets read zero.
- R3: Control bit i enables window i. A disabled window never takes part in decoding.
- R4: Window i matches address A when (A[31:16] & ~M) == (B[31:16] & ~M). Here B is the base register, and M is size bits [31:16], programmed as (size / 64 KB) - 1.
- R5: When more than one enabled window matches, the lowest index is selected.
- R6: On a hit or a violation, the attribute output equals bits [15:8] of the selected window's base register, and the window output equals its index.
- R7: Control bits [17+2i:16+2i] are window i's permission: bit 16+2i allows reads and bit 17+2i allows writes, so 3 grants full access. If the selected window lacks the bit the access needs, the block raises a protection violation instead of a hit.
- R8: If no enabled window matches, the block raises a decode miss, and the window and attribute outputs are zero.
- R9: The response valid is asserted exactly one cycle after each lookup, with exactly one of hit, miss or violation set. While valid is low, all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_write | input | 1 | Lookup is a write (1) or read (0) |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Access allowed in the selected window |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_prot_err | output | 1 | Selected window forbids this access |
| rsp_win | output | IDX_W | Selected window index |
| rsp_attr | output | 8 | Selected window attribute byte |

## Verification
The bench builds the decoder with four windows. This keeps the register map down to ten mapped offsets, so offsets 10 to 15 exercise the unmapped path, and it makes sweeping every enable pattern practical. It programs two pairs of overlapping windows with different mask widths. For all 16 enable patterns and four rotations of the permission fields, it looks up addresses at window edges and just outside them, both as reads and as writes. Every priority clash, disabled-window shadow, permission combination and miss case is reached, and the bench compares each result with an arithmetic model of the match rule.

// File: rtl/awd_pkg.sv
// Package: shared constants and the per-window configuration type.
// Assumes 32-bit addresses decoded at 64 KB granularity.
package awd_pkg;
    localparam int ADDR_W    = 32;
    localparam int GRAN_LOG2 = 16;
    localparam int PAGE_W    = ADDR_W - GRAN_LOG2;
    localparam int ATTR_W    = 8;
    localparam int ATTR_LSB  = 8;
    localparam int MAX_WIN   = 8;
    localparam int ACC_LSB   = 16;
    localparam int ACC_RD    = 0;
    localparam int ACC_WR    = 1;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_OVRD  = 1;
    localparam int OFS_WIN0  = 2;

    typedef struct packed {
        logic              en;
        logic [1:0]        acc;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] mask;
        logic [ATTR_W-1:0] attr;
    } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
// Module: register storage and read mux for the window decoder.
// Assumes word offsets: 0 control, 1 override, 2+2i base, 3+2i size.
// Bits without storage read as zero; unmapped offsets ignore writes.
module awd_regfile #(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output awd_pkg::win_cfg_t     cfg [NUM_WIN]
);
    import awd_pkg::*;

    logic [31:0] ovrd_q;

    // Override word: stored and read back only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovrd_q <= '0;
        else if (reg_we && reg_addr == REG_AW'(OFS_OVRD))
            ovrd_q <= reg_wdata;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int BASE_OFS = OFS_WIN0 + 2 * i;
        localparam int SIZE_OFS = OFS_WIN0 + 2 * i + 1;

        // Enable and permission bits of window i, from the control word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[i].en  <= 1'b0;
                cfg[i].acc <= 2'b00;
            end else if (reg_we && reg_addr == REG_AW'(OFS_CTRL)) begin
                cfg[i].en  <= reg_wdata[i];
                cfg[i].acc <= reg_wdata[ACC_LSB + 2*i +: 2];
            end
        end

        // Base page and attribute byte of window i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[i].base <= '0;
                cfg[i].attr <= '0;
            end else if (reg_we && reg_addr == REG_AW'(BASE_OFS)) begin
                cfg[i].base <= reg_wdata[ADDR_W-1:GRAN_LOG2];
                cfg[i].attr <= reg_wdata[ATTR_LSB +: ATTR_W];
            end
        end

        // Size mask of window i, in 64 KB units.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[i].mask <= '0;
            else if (reg_we && reg_addr == REG_AW'(SIZE_OFS))
                cfg[i].mask <= reg_wdata[ADDR_W-1:GRAN_LOG2];
        end
    end

    // Read mux: rebuild each register image from stored fields.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_CTRL)) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                reg_rdata[i]                 = cfg[i].en;
                reg_rdata[ACC_LSB + 2*i +: 2] = cfg[i].acc;
            end
        end else if (reg_addr == REG_AW'(OFS_OVRD)) begin
            reg_rdata = ovrd_q;
        end else begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (reg_addr == REG_AW'(OFS_WIN0 + 2*i))
                    reg_rdata = {cfg[i].base, cfg[i].attr, 8'h00};
                else if (reg_addr == REG_AW'(OFS_WIN0 + 2*i + 1))
                    reg_rdata = {cfg[i].mask, 16'h0000};
            end
        end
    end
endmodule

// File: rtl/awd_match.sv
// Module: per-window address comparators.
// Assumes the mask has ones for the page bits inside the window.
// Produces one match bit per enabled window.
module awd_match #(
    parameter int NUM_WIN = 8
) (
    input  awd_pkg::win_cfg_t               cfg [NUM_WIN],
    input  logic [awd_pkg::PAGE_W-1:0]      page,
    output logic [NUM_WIN-1:0]              match
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        // Masked compare of the address page against window i's base.
        always_comb begin
            match[i] = cfg[i].en &&
                       ((page & ~cfg[i].mask) == (cfg[i].base & ~cfg[i].mask));
        end
    end
endmodule

// File: rtl/awd_prio.sv
// Module: fixed-priority encoder, with the lowest index winning.
// Assumes nothing about how many request bits are set.
module awd_prio #(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/awd_decoder.sv
// Module: top of the address window decoder.
// Classifies each lookup as hit, miss or protection violation one
// cycle later. Assumes NUM_WIN <= 8, because the control word holds
// 8 enables and 8 permission fields.
module awd_decoder #(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = $clog2(2 + 2 * NUM_WIN),
    parameter int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_prot_err,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [7:0]        rsp_attr
);
    import awd_pkg::*;

    win_cfg_t           cfg [NUM_WIN];
    logic [NUM_WIN-1:0] match;
    logic               any_match;
    logic [IDX_W-1:0]   sel_idx;
    win_cfg_t           sel_cfg;
    logic               allowed;

    awd_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg   (cfg),
        .page  (lk_addr[ADDR_W-1:GRAN_LOG2]),
        .match (match)
    );

    awd_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
        .req (match),
        .any (any_match),
        .idx (sel_idx)
    );

    // Pick the selected window and test the permission the access needs.
    always_comb begin
        sel_cfg = cfg[0];
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_idx == IDX_W'(i))
                sel_cfg = cfg[i];
        end
        allowed = lk_write ? sel_cfg.acc[ACC_WR] : sel_cfg.acc[ACC_RD];
    end

    // Response register: one outcome per lookup, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_prot_err <= 1'b0;
            rsp_win      <= '0;
            rsp_attr     <= '0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_hit      <= lk_valid &&  any_match &&  allowed;
            rsp_prot_err <= lk_valid &&  any_match && !allowed;
            rsp_miss     <= lk_valid && !any_match;
            rsp_win      <= (lk_valid && any_match) ? sel_idx : '0;
            rsp_attr     <= (lk_valid && any_match) ? sel_cfg.attr : '0;
        end
    end
endmodule

// File: rtl/awd_checker.sv
// Module: protocol checks on the decoder response, bound to every instance.
module awd_checker #(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_prot_err,
    input logic [IDX_W-1:0] rsp_win,
    input logic [7:0]       rsp_attr
);
    initial begin
        assert_win_count_R3: assert (NUM_WIN >= 2 && NUM_WIN <= awd_pkg::MAX_WIN);
    end

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_err}) == 1);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot_err));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_win == '0 && rsp_attr == 8'h00));
endmodule

bind awd_decoder awd_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_awd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_prot_err (rsp_prot_err),
    .rsp_win      (rsp_win),
    .rsp_attr     (rsp_attr)
);

// File: tb/tb_awd_decoder.sv
module tb_awd_decoder;
    localparam int NW  = 4;
    localparam int RAW = $clog2(2 + 2 * NW);
    localparam int IW  = $clog2(NW);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           lk_valid = 1'b0;
    logic [31:0]    lk_addr = '0;
    logic           lk_write = 1'b0;
    logic           rsp_valid, rsp_hit, rsp_miss, rsp_prot_err;
    logic [IW-1:0]  rsp_win;
    logic [7:0]     rsp_attr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_base [NW];
    logic [15:0] m_mask [NW];
    logic [7:0]  m_attr [NW];
    logic [NW-1:0] m_en;
    logic [1:0]  m_acc [NW];

    awd_decoder #(.NUM_WIN(NW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_write(lk_write), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot_err(rsp_prot_err),
        .rsp_win(rsp_win), .rsp_attr(rsp_attr)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic reg_wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(string tag, int a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = RAW'(a);
        #1;
        check(tag, $sformatf("read offset %0d", a), reg_rdata, exp);
    endtask

    function automatic logic [31:0] ctrl_word();
        logic [31:0] w = '0;
        for (int i = 0; i < NW; i++) begin
            w[i] = m_en[i];
            w[16 + 2*i +: 2] = m_acc[i];
        end
        return w;
    endfunction

    task automatic program_all();
        for (int i = 0; i < NW; i++) begin
            reg_wr(2 + 2*i, {m_base[i], m_attr[i], 8'h00});
            reg_wr(3 + 2*i, {m_mask[i], 16'h0000});
        end
        reg_wr(0, ctrl_word());
    endtask

    // One lookup; the result is registered at the next rising edge and sampled at the falling edge after it.
    task automatic lookup(logic [31:0] a, logic wr);
        int first = -1; int nmatch = 0; int nshadow = 0;
        logic e_hit, e_prot, e_miss; logic [7:0] e_attr; logic [IW-1:0] e_win;
        string tg;
        for (int i = 0; i < NW; i++) begin
            if ((a[31:16] & ~m_mask[i]) == (m_base[i] & ~m_mask[i])) begin
                if (m_en[i]) begin
                    nmatch++;
                    if (first < 0) first = i;
                end else nshadow++;
            end
        end
        e_miss = (first < 0);
        e_hit  = !e_miss && (wr ? m_acc[first][1] : m_acc[first][0]);
        e_prot = !e_miss && !e_hit;
        e_win  = e_miss ? '0 : IW'(first);
        e_attr = e_miss ? 8'h00 : m_attr[first];
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
        if (e_miss) tg = (nshadow > 0) ? "R3" : "R8";
        else if (e_prot) tg = "R7";
        else if (nmatch > 1) tg = "R5";
        else tg = "R4";
        check("R9", "valid", {31'd0, rsp_valid}, 32'd1);
        check(tg, $sformatf("flags hit/miss/prot a=%h w=%0d", a, wr),
              {29'd0, rsp_hit, rsp_miss, rsp_prot_err}, {29'd0, e_hit, e_miss, e_prot});
        check(e_miss ? "R8" : "R6", "window", {{(32-IW){1'b0}}, rsp_win}, {{(32-IW){1'b0}}, e_win});
        check(e_miss ? "R8" : "R6", "attr", {24'd0, rsp_attr}, {24'd0, e_attr});
    endtask

    initial begin
        logic [31:0] addrs [10];
        addrs = '{32'h1000_0000, 32'h1000_FFFF, 32'h1001_0000, 32'h1FFF_FFFF,
                  32'h2000_0000, 32'h200F_FFFF, 32'h2010_0000, 32'h20FF_FFFF,
                  32'h2100_0000, 32'h0FFF_FFFF};
        for (int i = 0; i < NW; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_attr[i] = '0; m_acc[i] = '0;
        end
        m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and a lookup that misses.
        for (int a = 0; a < 2 + 2*NW; a++) reg_chk("R1", a, 32'h0);
        lookup(32'h0000_0000, 1'b0);
        check("R1", "miss after reset", {31'd0, rsp_miss}, 32'd1);
        @(negedge clk);
        check("R9", "valid drops when idle", {31'd0, rsp_valid}, 32'd0);

        // R2: read-back masking and unmapped offsets.
        reg_wr(0, 32'hFFFF_FFFF);  reg_chk("R2", 0, 32'h00FF_000F);
        reg_wr(1, 32'hA5C3_5A3C);  reg_chk("R2", 1, 32'hA5C3_5A3C);
        for (int i = 0; i < NW; i++) begin
            reg_wr(2 + 2*i, 32'h1234_5678 + 32'(i)); reg_chk("R2", 2 + 2*i, (32'h1234_5678 + 32'(i)) & 32'hFFFF_FF00);
            reg_wr(3 + 2*i, 32'hFEDC_BA98);          reg_chk("R2", 3 + 2*i, 32'hFEDC_0000);
        end
        for (int a = 2 + 2*NW; a < (1 << RAW); a++) begin
            reg_wr(a, 32'hFFFF_FFFF); reg_chk("R2", a, 32'h0);
        end
        reg_chk("R2", 1, 32'hA5C3_5A3C);
        reg_wr(0, 32'h0);

        // Overlapping windows: 0 and 1 share a base, 2 and 3 share a base.
        m_base[0] = 16'h1000; m_mask[0] = 16'h0FFF; m_attr[0] = 8'h0E;
        m_base[1] = 16'h1000; m_mask[1] = 16'h0000; m_attr[1] = 8'h0D;
        m_base[2] = 16'h2000; m_mask[2] = 16'h000F; m_attr[2] = 8'h0B;
        m_base[3] = 16'h2000; m_mask[3] = 16'h00FF; m_attr[3] = 8'h07;

        // R3 R4 R5 R6 R7 R8: all enable patterns, rotated permissions, read and write.
        for (int en = 0; en < (1 << NW); en++) begin
            for (int k = 0; k < 4; k++) begin
                m_en = NW'(en);
                for (int i = 0; i < NW; i++) m_acc[i] = 2'((k + i) % 4);
                program_all();
                for (int j = 0; j < 10; j++) begin
                    lookup(addrs[j], 1'b0);
                    lookup(addrs[j], 1'b1);
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule